// File: doc/BRIEF.md
# Predicated ALU with Condition Flags

This block is a one-cycle execution unit for a small datapath. It performs a compare, an add or a subtract, or does nothing, as the opcode selects. A compare of two signed 32-bit operands loads a 4-bit condition register. Each add or subtract carries a 4-bit condition mask and is checked against that register. The arithmetic commits only when the mask selects at least one flag that is set. Otherwise the write-enable stays low and the result output keeps its previous value.

Before the add or subtract, the second operand can be shifted left by an immediate amount, so one operation forms `a + (b << n)` or `a - (b << n)`. With this predication, a loop body such as the repeated-subtraction greatest common divisor needs no branch that depends on the data. The loop is a compare, then a subtract-if-greater, then a subtract-if-less-or-equal. Both subtracts read the flags from the same compare.

The unit accepts one operation every clock. Each operation's result, write-enable and flags appear on the outputs one clock later, all from registers.

Top module: `pred_alu`

## Requirements
- R1: After reset the flags are 0000, the write-enable is low and the result is 0.
- R2: A compare (opcode 01) loads the flags one cycle later. Bit 3 is equal, bit 2 is not-equal, bit 1 is less-than and bit 0 is greater-than. Comparing 4 with 3 gives 0101, and comparing 5 with 5 gives 1000.
- R3: The compare is signed two's complement. After every compare, exactly one of equal, less and greater is set, and not-equal is the inverse of equal.
- R4: Only a compare changes the flags. Add, subtract and no-op leave them unchanged.
- R5: An add (opcode 10) or subtract (opcode 11) executes when the bitwise AND of the flags and the mask is nonzero, or when the mask is 1111, whatever the flags hold. When it executes, the write-enable is high on the next cycle.
- R6: When the predicate fails, the write-enable is low on the next cycle and the result keeps its previous value.
- R7: An executed add gives `a + (b << shamt)` modulo 2^32. A shift amount of 0 passes b through unchanged.
- R8: An executed subtract gives `a - (b << shamt)` modulo 2^32.
- R9: A no-op (opcode 00) or a compare drives the write-enable low and leaves the result unchanged.
- R10: Repeating a compare of i and j, then a subtract i-j with mask 0001, then a subtract j-i with mask 1010 reaches a state where the compare gives 1000. At that point i equals the greatest common divisor of the starting values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Opcode: 00 no-op, 01 compare, 10 add, 11 subtract |
| mask_i | input | 4 | Condition mask for add and subtract |
| shamt_i | input | 5 | Left shift applied to b before add or subtract |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| res_o | output | 32 | Registered result of the last executed add or subtract |
| wr_en_o | output | 1 | High for one cycle after an executed add or subtract |
| flags_o | output | 4 | Condition register {eq, ne, lt, gt} |

## Verification
The assertions assume that every opcode value is meaningful and that all four are legal in any order, with no handshake. The flag properties also rely on the flags being 0000 only from reset until the first compare. The stimulus mixes directed compares, including equal, sign-crossing and extreme operands, with a random stream of all four opcodes and all mask and shift values. Operands are often drawn from a small range, so that compares come out equal often enough to exercise each predicate outcome. The divisor loops use only positive operands, so every subtraction stays positive and the loop ends.

// File: rtl/pred_alu_pkg.sv
package pred_alu_pkg;

  typedef enum logic [1:0] {
    OP_NOP = 2'b00,
    OP_CMP = 2'b01,
    OP_ADD = 2'b10,
    OP_SUB = 2'b11
  } pa_op_e;

  localparam int unsigned FLAG_W = 4;
  localparam int unsigned FL_EQ  = 3;
  localparam int unsigned FL_NE  = 2;
  localparam int unsigned FL_LT  = 1;
  localparam int unsigned FL_GT  = 0;

endpackage

// File: rtl/pa_flag_gen.sv
module pa_flag_gen
  import pred_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [FLAG_W-1:0] flags_o
);

  function automatic logic [FLAG_W-1:0] signed_compare(
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b
  );
    logic [FLAG_W-1:0] f;
    logic eq;
    logic lt;
    eq = (a == b);
    lt = ($signed(a) < $signed(b));
    f = '0;
    f[FL_EQ] = eq;
    f[FL_NE] = ~eq;
    f[FL_LT] = lt;
    f[FL_GT] = ~eq & ~lt;
    return f;
  endfunction

  assign flags_o = signed_compare(a_i, b_i);

endmodule

// File: rtl/pa_shift_alu.sv
module pa_shift_alu #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SH_W   = 5
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic              is_sub_i,
  output logic [DATA_W-1:0] result_o
);

  function automatic logic [DATA_W-1:0] shift_op(
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input logic [SH_W-1:0]   sh,
    input logic              sub
  );
    logic [DATA_W-1:0] bs;
    bs = b << sh;
    if (sub) return a - bs;
    return a + bs;
  endfunction

  assign result_o = shift_op(a_i, b_i, shamt_i, is_sub_i);

endmodule

// File: rtl/pa_pred_eval.sv
module pa_pred_eval
  import pred_alu_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [FLAG_W-1:0] mask_i,
  output logic              take_o
);

  logic [FLAG_W-1:0] hit;
  logic              always_w;

  for (genvar g = 0; g < FLAG_W; g++) begin : g_hit
    assign hit[g] = flags_i[g] & mask_i[g];
  end

  assign always_w = &mask_i;
  assign take_o   = always_w | (|hit);

endmodule

// File: rtl/pred_alu.sv
module pred_alu
  import pred_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_i,
  input  logic [3:0]        mask_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wr_en_o,
  output logic [3:0]        flags_o
);

  pa_op_e            op_w;
  logic [FLAG_W-1:0] cmp_flags_w;
  logic [DATA_W-1:0] alu_out_w;
  logic              take_w;
  logic              is_arith_w;
  logic              commit_w;

  logic [FLAG_W-1:0] flags_q;
  logic [DATA_W-1:0] res_q;
  logic              we_q;

  assign op_w       = pa_op_e'(op_i);
  assign is_arith_w = (op_w == OP_ADD) || (op_w == OP_SUB);
  assign commit_w   = is_arith_w && take_w;

  pa_flag_gen #(.DATA_W(DATA_W)) u_flag_gen (
    .a_i     (a_i),
    .b_i     (b_i),
    .flags_o (cmp_flags_w)
  );

  pa_shift_alu #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift_alu (
    .a_i      (a_i),
    .b_i      (b_i),
    .shamt_i  (shamt_i),
    .is_sub_i (op_w == OP_SUB),
    .result_o (alu_out_w)
  );

  pa_pred_eval u_pred_eval (
    .flags_i (flags_q),
    .mask_i  (mask_i),
    .take_o  (take_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      res_q   <= '0;
      we_q    <= 1'b0;
    end else begin
      we_q <= commit_w;
      if (op_w == OP_CMP) flags_q <= cmp_flags_w;
      if (commit_w)       res_q   <= alu_out_w;
    end
  end

  assign res_o   = res_q;
  assign wr_en_o = we_q;
  assign flags_o = flags_q;

endmodule

// File: rtl/pred_alu_chk.sv
module pred_alu_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        op_i,
  input logic [3:0]        flags_o,
  input logic [DATA_W-1:0] res_o,
  input logic              wr_en_o,
  input logic [3:0]        cmp_flags_w,
  input logic              take_w
);

  logic arith_w;
  assign arith_w = op_i[1];

  p_flag_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o != 4'b0000) |-> ($onehot({flags_o[3], flags_o[1], flags_o[0]}) && (flags_o[2] == !flags_o[3])));

  p_cmp_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b01) |=> (flags_o == $past(cmp_flags_w)));

  p_flags_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i != 2'b01) |=> $stable(flags_o));

  p_we_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arith_w && take_w) |=> wr_en_o);

  p_we_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(arith_w && take_w) |=> !wr_en_o);

  p_res_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_o |-> $stable(res_o));

endmodule

bind pred_alu pred_alu_chk #(.DATA_W(DATA_W)) u_pred_alu_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_i        (op_i),
  .flags_o     (flags_o),
  .res_o       (res_o),
  .wr_en_o     (wr_en_o),
  .cmp_flags_w (cmp_flags_w),
  .take_w      (take_w)
);

// File: tb/test_pred_alu.sv
`timescale 1ns/1ps
module test_pred_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [3:0]  mask_i = 4'h0;
  logic [4:0]  shamt_i = 5'd0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [31:0] res_o;
  logic        wr_en_o;
  logic [3:0]  flags_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [3:0]  m_flags;
  logic [31:0] m_res;
  logic        m_we;

  always #2.5 clk = ~clk;

  pred_alu i_pred_alu (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .mask_i(mask_i), .shamt_i(shamt_i),
    .a_i(a_i), .b_i(b_i), .res_o(res_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
  );

  function automatic logic [3:0] model_flags(input logic [31:0] a, input logic [31:0] b);
    int signed sa;
    int signed sb;
    sa = a;
    sb = b;
    if (sa == sb) return 4'b1000;
    else if (sa < sb) return 4'b0110;
    else return 4'b0101;
  endfunction

  function automatic logic [31:0] model_arith(input logic [1:0] op, input logic [31:0] a,
                                              input logic [31:0] b, input logic [4:0] sh);
    logic [63:0] scaled;
    scaled = {32'd0, b} * (64'd1 << sh);
    if (op == 2'b11) return a - scaled[31:0];
    return a + scaled[31:0];
  endfunction

  function automatic int sw_gcd(input int x, input int y);
    int t;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [3:0] mask, input logic [4:0] sh,
                        input logic [31:0] a, input logic [31:0] b, input string tag, input bit check);
    bit take;
    op_i = op; mask_i = mask; shamt_i = sh; a_i = a; b_i = b;
    m_we = 1'b0;
    if (op == 2'b01) m_flags = model_flags(a, b);
    else if (op[1]) begin
      take = (mask == 4'hF) || ((m_flags & mask) != 4'h0);
      if (take) begin
        m_res = model_arith(op, a, b, sh);
        m_we  = 1'b1;
      end
    end
    @(negedge clk);
    if (check) begin
      chk({tag, " flags"}, {28'd0, flags_o}, {28'd0, m_flags});
      chk({tag, " wr_en"}, {31'd0, wr_en_o}, {31'd0, m_we});
      chk({tag, " result"}, res_o, m_res);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 12345;
    void'($urandom(seed));
    m_flags = 4'h0; m_res = '0; m_we = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 flags", {28'd0, flags_o}, 32'd0);
    chk("R1 wr_en", {31'd0, wr_en_o}, 32'd0);
    chk("R1 result", res_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 mask 1111 executes even with flags 0000
    run_op(2'b10, 4'hF, 5'd0, 32'd7, 32'd9, "R5 always-mask", 1);
    // R6 mask 0001 with flags 0000 fails, result held
    run_op(2'b11, 4'h1, 5'd0, 32'd100, 32'd1, "R6 fail-hold", 1);
    // R2 compare 4,3 -> 0101 and 5,5 -> 1000
    run_op(2'b01, 4'h0, 5'd0, 32'd4, 32'd3, "R2 cmp 4 3", 1);
    chk("R2 value 0101", {28'd0, flags_o}, 32'h5);
    run_op(2'b01, 4'h0, 5'd0, 32'd5, 32'd5, "R2 cmp 5 5", 1);
    chk("R2 value 1000", {28'd0, flags_o}, 32'h8);
    // R3 signed: -1 < 1 ; 0x7fffffff > 0x80000000
    run_op(2'b01, 4'h0, 5'd0, 32'hFFFF_FFFF, 32'd1, "R3 signed lt", 1);
    chk("R3 value 0110", {28'd0, flags_o}, 32'h6);
    run_op(2'b01, 4'h0, 5'd0, 32'h7FFF_FFFF, 32'h8000_0000, "R3 signed gt", 1);
    chk("R3 value 0101", {28'd0, flags_o}, 32'h5);
    // R7 shift by 4 multiplies by 16; shift 0 passes through; wrap
    run_op(2'b10, 4'h1, 5'd4, 32'd10, 32'd3, "R7 shift4", 1);
    chk("R7 value 58", res_o, 32'd58);
    run_op(2'b10, 4'h1, 5'd0, 32'd10, 32'd3, "R7 shift0", 1);
    run_op(2'b10, 4'hF, 5'd31, 32'hFFFF_FFFF, 32'd3, "R7 wrap", 1);
    // R8 subtract with shift
    run_op(2'b11, 4'h4, 5'd2, 32'd100, 32'd5, "R8 sub", 1);
    chk("R8 value 80", res_o, 32'd80);
    // R4 flags unchanged by arithmetic; R9 no-op and compare hold result
    run_op(2'b11, 4'h8, 5'd0, 32'd1, 32'd1, "R6 pred-fail", 1);
    run_op(2'b00, 4'hF, 5'd3, 32'd9, 32'd9, "R9 nop", 1);
    run_op(2'b01, 4'hF, 5'd0, 32'd9, 32'd9, "R9 cmp", 1);
    run_op(2'b10, 4'h8, 5'd1, 32'd2, 32'd2, "R4 arith-keeps-flags", 1);

    // Random mix: R4 R5 R6 R7 R8 R9
    for (int n = 0; n < 400; n++) begin
      logic [31:0] ra;
      logic [31:0] rb;
      if ($urandom % 2) begin
        ra = $urandom % 8;
        rb = $urandom % 8;
      end else begin
        ra = $urandom;
        rb = $urandom;
      end
      run_op(2'($urandom), 4'($urandom), 5'($urandom), ra, rb, "R5 random", 1);
    end

    // R10 divisor loop by predicated subtraction
    for (int p = 0; p < 6; p++) begin
      int ii;
      int jj;
      int i0;
      int j0;
      int guard;
      case (p)
        0: begin i0 = 48;  j0 = 18;  end
        1: begin i0 = 7;   j0 = 13;  end
        2: begin i0 = 100; j0 = 75;  end
        3: begin i0 = 17;  j0 = 17;  end
        default: begin i0 = 1 + ($urandom % 300); j0 = 1 + ($urandom % 300); end
      endcase
      ii = i0; jj = j0; guard = 0;
      forever begin
        run_op(2'b01, 4'h0, 5'd0, ii, jj, "R10 cmp", 0);
        if (flags_o == 4'b1000 || guard > 1000) break;
        run_op(2'b11, 4'b0001, 5'd0, ii, jj, "R10 subgt", 0);
        if (wr_en_o) ii = res_o;
        run_op(2'b11, 4'b1010, 5'd0, jj, ii, "R10 suble", 0);
        if (wr_en_o) jj = res_o;
        guard++;
      end
      chk("R10 gcd", ii, sw_gcd(i0, j0));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule